// File: doc/BRIEF.md
# Firmware Image Boot Sequencer

This block runs once after every reset and decides which of three firmware images the system starts from. The order of preference is fixed. The upgrade image comes first, and only when the host has asked for it. The golden image comes next, and the recovery image is the last resort. Each attempt asks an external loader to load one image. The loader reports the result with a single done pulse that carries a pass/fail flag. An image whose presence flag is low is skipped at once, without any request to the loader.

The outcome is collected in a 5-bit status word, `{image_type, recovery, fallback, progress[1:0]}`, which a host reads through a registered read port. The progress codes are:

- `00`: not started
- `01`: in progress
- `10`: failed
- `11`: succeeded

`fallback` shows that a requested upgrade image was skipped or failed. `recovery` shows that the recovery image had to be used. `image_type` is 1 when the upgrade image booted and 0 when the golden image booted. It carries meaning only while `recovery` is 0.

The load request is a valid/ready stream with no buffering. Once `ld_valid_o` rises, it stays high with `ld_image_o` unchanged until the loader accepts it with `ld_ready_i`. The image codes are 0 for upgrade, 1 for golden and 2 for recovery. A loader may hold off acceptance for any number of cycles.

Top module: `fwboot_sequencer`

## Requirements
- R1: While reset is asserted, the read data is 5'b00000 and no load request is raised.
- R2: While an attempt is under way, the progress field reads 2'b01.
- R3: With no upgrade requested, the first request names image 1 (golden). If it passes, the status is 5'b00011 and the fallback bit stays clear.
- R4: With an upgrade requested and present, the first request names image 0. If it passes, the status is 5'b10011 (image_type=1).
- R5: A requested upgrade image that is absent is skipped with no request for image 0. Golden is requested next, and a golden pass gives 5'b00111.
- R6: A requested upgrade image that reports fail is followed by a golden request, and a golden pass gives 5'b00111.
- R7: A golden image that is absent or fails leads to a request for image 2 (recovery). A recovery pass sets the recovery bit and leaves image_type 0. This gives 5'b01011 with no upgrade requested and 5'b01111 after a failed upgrade.
- R8: When recovery is absent or fails, progress becomes 2'b10 (for example 5'b01110 or 5'b01010). No further request is raised and the status holds until reset.
- R9: A raised load request keeps ld_valid_o high and ld_image_o stable until the cycle in which ld_ready_i is high. Each attempt raises exactly one request.
- R10: A done pulse that arrives when no accepted request is pending is ignored.
- R11: Asserting reset part-way through a sequence abandons it. The sequence restarts with the inputs present at the new start.
- R12: rd_data_o takes the status value one cycle after a cycle with rd_en_i high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; restarts the sequence |
| upgrade_req_i | input | 1 | Host asks for the upgrade image (sampled at sequence start) |
| img_present_i | input | 3 | Presence flags: bit0 upgrade, bit1 golden, bit2 recovery |
| ld_valid_o | output | 1 | Load request valid |
| ld_ready_i | input | 1 | Loader accepts the request |
| ld_image_o | output | 2 | Image to load: 0 upgrade, 1 golden, 2 recovery |
| att_done_i | input | 1 | One-cycle pulse: the accepted attempt has finished |
| att_pass_i | input | 1 | Result carried with att_done_i: 1 pass, 0 fail |
| rd_en_i | input | 1 | Read strobe for the status word |
| rd_data_o | output | 5 | Status word {image_type, recovery, fallback, progress} |

## Verification
The bench covers every path through the three tiers: absent images, images that fail, and a recovery that also fails. A design with a wrong priority, or with skips that mishandle absence, would request the wrong image first, or request an absent one. A design that mis-set the flags would report the wrong fallback or recovery bits, or a stale image_type after a recovery boot.

The bench also checks the edges of the handshake. In one case it holds ready low for several cycles, and a design that dropped or changed its request there would show up. In another case it sends a stray done pulse before acceptance, which a sloppy design would take as a result. After a final failure it sends more done pulses, which must raise no new request. A reset part-way through a sequence checks that stale tier state is not carried over. Finally, a read-port hold check catches a read register that follows the status without a strobe.

// File: rtl/fwboot_pkg.sv
`timescale 1ns/1ps
package fwboot_pkg;
  localparam int N_IMG = 3;
  localparam int IMG_W = $clog2(N_IMG);

  typedef enum logic [1:0] {
    PROG_IDLE = 2'b00,
    PROG_BUSY = 2'b01,
    PROG_FAIL = 2'b10,
    PROG_OK   = 2'b11
  } prog_e;

  typedef enum logic [IMG_W-1:0] {
    IMG_UPG   = 2'd0,
    IMG_GOLD  = 2'd1,
    IMG_RECOV = 2'd2
  } img_e;

  typedef struct packed {
    logic  img_type;
    logic  recov;
    logic  fallbk;
    prog_e prog;
  } stat_t;

  localparam int STAT_W = $bits(stat_t);
endpackage

// File: rtl/fwboot_tier_step.sv
`timescale 1ns/1ps
// Fallback order: which tier follows the current one, and which flag the move sets.
module fwboot_tier_step
  import fwboot_pkg::*;
(
  input  img_e       cur_i,
  input  logic [N_IMG-1:0] present_i,
  output img_e       nxt_o,
  output logic       last_o,
  output logic       here_o,
  output logic       set_fb_o,
  output logic       set_rc_o
);
  always_comb begin
    nxt_o    = IMG_RECOV;
    last_o   = 1'b0;
    set_fb_o = 1'b0;
    set_rc_o = 1'b0;
    here_o   = present_i[2];
    case (cur_i)
      IMG_UPG: begin
        nxt_o    = IMG_GOLD;
        set_fb_o = 1'b1;
        here_o   = present_i[0];
      end
      IMG_GOLD: begin
        nxt_o    = IMG_RECOV;
        set_rc_o = 1'b1;
        here_o   = present_i[1];
      end
      default: begin
        nxt_o  = IMG_RECOV;
        last_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fwboot_ctrl.sv
`timescale 1ns/1ps
// Sequencing FSM: one attempt per tier, load request as a valid/ready stream.
module fwboot_ctrl
  import fwboot_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upgrade_req_i,
  input  logic [N_IMG-1:0] present_i,
  input  logic             ld_ready_i,
  input  logic             att_done_i,
  input  logic             att_pass_i,
  output logic             ld_valid_o,
  output img_e             cur_o,
  output logic             ev_start_o,
  output logic             ev_fb_o,
  output logic             ev_rc_o,
  output logic             ev_ok_o,
  output logic             ev_bad_o
);
  typedef enum logic [2:0] {
    S_INIT, S_PICK, S_REQ, S_WAIT, S_HALT
  } st_e;

  st_e  st_q;
  img_e cur_q;
  img_e nxt;
  logic last, here, set_fb, set_rc;
  logic advance;

  fwboot_tier_step u_step (
    .cur_i     (cur_q),
    .present_i (present_i),
    .nxt_o     (nxt),
    .last_o    (last),
    .here_o    (here),
    .set_fb_o  (set_fb),
    .set_rc_o  (set_rc)
  );

  // A tier is given up when it is absent or its accepted attempt reports fail.
  assign advance = ((st_q == S_PICK) && !here) ||
                   ((st_q == S_WAIT) && att_done_i && !att_pass_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_INIT;
      cur_q <= IMG_GOLD;
    end else begin
      case (st_q)
        S_INIT: begin
          cur_q <= upgrade_req_i ? IMG_UPG : IMG_GOLD;
          st_q  <= S_PICK;
        end
        S_PICK: begin
          if (here) st_q <= S_REQ;
        end
        S_REQ: begin
          if (ld_ready_i) st_q <= S_WAIT;
        end
        S_WAIT: begin
          if (att_done_i && att_pass_i) st_q <= S_HALT;
        end
        default: st_q <= S_HALT;
      endcase
      if (advance) begin
        if (last) begin
          st_q <= S_HALT;
        end else begin
          cur_q <= nxt;
          st_q  <= S_PICK;
        end
      end
    end
  end

  assign ld_valid_o = (st_q == S_REQ);
  assign cur_o      = cur_q;
  assign ev_start_o = (st_q == S_INIT);
  assign ev_fb_o    = advance && set_fb;
  assign ev_rc_o    = advance && set_rc;
  assign ev_ok_o    = (st_q == S_WAIT) && att_done_i && att_pass_i;
  assign ev_bad_o   = advance && last;
endmodule

// File: rtl/fwboot_status.sv
`timescale 1ns/1ps
// Status word built from sequencing events, plus the registered read port.
module fwboot_status
  import fwboot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  img_e              cur_i,
  input  logic              ev_start_i,
  input  logic              ev_fb_i,
  input  logic              ev_rc_i,
  input  logic              ev_ok_i,
  input  logic              ev_bad_i,
  input  logic              rd_en_i,
  output stat_t             stat_o,
  output logic [STAT_W-1:0] rd_data_o
);
  stat_t stat_q;
  logic [STAT_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '{img_type: 1'b0, recov: 1'b0, fallbk: 1'b0, prog: PROG_IDLE};
    end else begin
      if (ev_start_i) begin
        stat_q <= '{img_type: 1'b0, recov: 1'b0, fallbk: 1'b0, prog: PROG_BUSY};
      end
      if (ev_fb_i)  stat_q.fallbk <= 1'b1;
      if (ev_rc_i)  stat_q.recov  <= 1'b1;
      if (ev_ok_i) begin
        stat_q.prog     <= PROG_OK;
        stat_q.img_type <= (cur_i == IMG_UPG);
      end
      if (ev_bad_i) stat_q.prog <= PROG_FAIL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= stat_q;
  end

  assign stat_o    = stat_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/fwboot_sequencer.sv
`timescale 1ns/1ps
module fwboot_sequencer
  import fwboot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upgrade_req_i,
  input  logic [N_IMG-1:0]  img_present_i,
  output logic              ld_valid_o,
  input  logic              ld_ready_i,
  output logic [IMG_W-1:0]  ld_image_o,
  input  logic              att_done_i,
  input  logic              att_pass_i,
  input  logic              rd_en_i,
  output logic [STAT_W-1:0] rd_data_o
);
  img_e  cur;
  stat_t stat_w;
  logic  ev_start, ev_fb, ev_rc, ev_ok, ev_bad;

  fwboot_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .upgrade_req_i (upgrade_req_i),
    .present_i     (img_present_i),
    .ld_ready_i    (ld_ready_i),
    .att_done_i    (att_done_i),
    .att_pass_i    (att_pass_i),
    .ld_valid_o    (ld_valid_o),
    .cur_o         (cur),
    .ev_start_o    (ev_start),
    .ev_fb_o       (ev_fb),
    .ev_rc_o       (ev_rc),
    .ev_ok_o       (ev_ok),
    .ev_bad_o      (ev_bad)
  );

  fwboot_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cur_i      (cur),
    .ev_start_i (ev_start),
    .ev_fb_i    (ev_fb),
    .ev_rc_i    (ev_rc),
    .ev_ok_i    (ev_ok),
    .ev_bad_i   (ev_bad),
    .rd_en_i    (rd_en_i),
    .stat_o     (stat_w),
    .rd_data_o  (rd_data_o)
  );

  assign ld_image_o = cur;
endmodule

// File: rtl/fwboot_sequencer_chk.sv
`timescale 1ns/1ps
module fwboot_sequencer_chk
  import fwboot_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ld_valid_o,
  input logic              ld_ready_i,
  input logic [IMG_W-1:0]  ld_image_o,
  input logic              rd_en_i,
  input logic [STAT_W-1:0] rd_data_o,
  input stat_t             stat_w
);
  // R9: request held with stable image until accepted
  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_o && !ld_ready_i) |=> (ld_valid_o && $stable(ld_image_o)));

  // R9: only the three defined image codes are ever requested
  p_img_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> (ld_image_o != 2'd3));

  // R8: a final failure is sticky until reset
  p_fail_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_w.prog == PROG_FAIL) |=> (stat_w.prog == PROG_FAIL));

  // R8: no request once a final result is recorded
  p_quiet_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_w.prog == PROG_FAIL || stat_w.prog == PROG_OK) |-> !ld_valid_o);

  // R7: recovery boot never reports the upgrade image type
  p_type_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_w.recov |-> !stat_w.img_type);

  // R12: read data holds without a strobe
  p_rd_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind fwboot_sequencer fwboot_sequencer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ld_valid_o (ld_valid_o),
  .ld_ready_i (ld_ready_i),
  .ld_image_o (ld_image_o),
  .rd_en_i    (rd_en_i),
  .rd_data_o  (rd_data_o),
  .stat_w     (stat_w)
);

// File: tb/fwboot_sequencer_test.sv
`timescale 1ns/1ps
module fwboot_sequencer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upg = 1'b0;
  logic [2:0] pres = 3'b000;
  logic       ld_valid;
  logic       ld_ready = 1'b0;
  logic [1:0] ld_image;
  logic       done = 1'b0;
  logic       pass = 1'b0;
  logic       rd_en = 1'b0;
  logic [4:0] rd_data;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  fwboot_sequencer uut (
    .clk_i(clk), .rst_ni(rst_n), .upgrade_req_i(upg), .img_present_i(pres),
    .ld_valid_o(ld_valid), .ld_ready_i(ld_ready), .ld_image_o(ld_image),
    .att_done_i(done), .att_pass_i(pass), .rd_en_i(rd_en), .rd_data_o(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start(input logic u, input logic [2:0] p);
    @(negedge clk);
    rst_n = 1'b0; upg = u; pres = p; ld_ready = 1'b0; done = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic read_status(output logic [4:0] v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wait_req(input string req, input logic [1:0] img);
    int n = 0;
    while (!ld_valid && n < 50) begin @(negedge clk); n++; end
    check(req, {31'd0, ld_valid}, 32'd1);
    check(req, {30'd0, ld_image}, {30'd0, img});
  endtask

  task automatic serve(input string req, input logic [1:0] img, input logic ok);
    wait_req(req, img);
    ld_ready = 1'b1;
    @(negedge clk); ld_ready = 1'b0; done = 1'b1; pass = ok;
    @(negedge clk); done = 1'b0; pass = 1'b0;
  endtask

  task automatic wait_final(output logic [4:0] v);
    v = 5'b00001;
    for (int i = 0; i < 40; i++) begin
      read_status(v);
      if (v[1:0] != 2'b01) break;
    end
  endtask

  task automatic t_reset;  // R1
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 rd_data", {27'd0, rd_data}, 32'd0);
    check("R1 ld_valid", {31'd0, ld_valid}, 32'd0);
  endtask

  task automatic t_golden_only;  // R2, R3
    logic [4:0] v;
    start(1'b0, 3'b111);
    wait_req("R3 first", 2'd1);
    read_status(v);
    check("R2 busy", {30'd0, v[1:0]}, 32'd1);
    serve("R3 golden", 2'd1, 1'b1);
    wait_final(v);
    check("R3 status", {27'd0, v}, 32'b00011);
  endtask

  task automatic t_upgrade_ok;  // R4
    logic [4:0] v;
    start(1'b1, 3'b111);
    serve("R4 upgrade", 2'd0, 1'b1);
    wait_final(v);
    check("R4 status", {27'd0, v}, 32'b10011);
  endtask

  task automatic t_upg_absent;  // R5
    logic [4:0] v;
    start(1'b1, 3'b110);
    serve("R5 golden", 2'd1, 1'b1);
    wait_final(v);
    check("R5 status", {27'd0, v}, 32'b00111);
  endtask

  task automatic t_upg_fail;  // R6
    logic [4:0] v;
    start(1'b1, 3'b111);
    serve("R6 upgrade", 2'd0, 1'b0);
    serve("R6 golden", 2'd1, 1'b1);
    wait_final(v);
    check("R6 status", {27'd0, v}, 32'b00111);
  endtask

  task automatic t_recovery;  // R7
    logic [4:0] v;
    start(1'b0, 3'b111);
    serve("R7 golden", 2'd1, 1'b0);
    serve("R7 recovery", 2'd2, 1'b1);
    wait_final(v);
    check("R7 status plain", {27'd0, v}, 32'b01011);
    start(1'b1, 3'b101);
    serve("R7 upgrade", 2'd0, 1'b0);
    serve("R7 recovery2", 2'd2, 1'b1);
    wait_final(v);
    check("R7 status upg", {27'd0, v}, 32'b01111);
  endtask

  task automatic t_all_fail;  // R8
    logic [4:0] v;
    int seen;
    start(1'b1, 3'b111);
    serve("R8 upgrade", 2'd0, 1'b0);
    serve("R8 golden", 2'd1, 1'b0);
    serve("R8 recovery", 2'd2, 1'b0);
    wait_final(v);
    check("R8 status", {27'd0, v}, 32'b01110);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); done = (i == 2); pass = (i == 2);
      if (ld_valid) seen++;
    end
    done = 1'b0; pass = 1'b0;
    check("R8 no request", seen, 0);
    read_status(v);
    check("R8 sticky", {27'd0, v}, 32'b01110);
    start(1'b0, 3'b000);
    seen = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (ld_valid) seen++; end
    check("R8 none present req", seen, 0);
    wait_final(v);
    check("R8 none present", {27'd0, v}, 32'b01010);
  endtask

  task automatic t_hold;  // R9
    logic [4:0] v;
    int drop;
    start(1'b0, 3'b111);
    wait_req("R9 raise", 2'd1);
    drop = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!ld_valid || ld_image != 2'd1) drop++;
    end
    check("R9 hold", drop, 0);
    serve("R9 accept", 2'd1, 1'b1);
    @(negedge clk);
    check("R9 single request", {31'd0, ld_valid}, 32'd0);
    wait_final(v);
    check("R9 status", {27'd0, v}, 32'b00011);
  endtask

  task automatic t_stray_done;  // R10
    logic [4:0] v;
    start(1'b1, 3'b111);
    wait_req("R10 raise", 2'd0);
    done = 1'b1; pass = 1'b0;
    @(negedge clk); done = 1'b0;
    check("R10 still pending", {29'd0, ld_valid, ld_image}, {29'd0, 1'b1, 2'd0});
    serve("R10 upgrade", 2'd0, 1'b1);
    wait_final(v);
    check("R10 status", {27'd0, v}, 32'b10011);
  endtask

  task automatic t_reset_mid;  // R11
    logic [4:0] v;
    start(1'b1, 3'b111);
    wait_req("R11 first", 2'd0);
    ld_ready = 1'b1;
    @(negedge clk); ld_ready = 1'b0;
    start(1'b0, 3'b111);
    read_status(v);
    check("R11 restarted", {27'd0, v}, 32'b00001);
    serve("R11 golden", 2'd1, 1'b1);
    wait_final(v);
    check("R11 status", {27'd0, v}, 32'b00011);
  endtask

  task automatic t_read_port;  // R12
    logic [4:0] v;
    start(1'b0, 3'b111);
    wait_req("R12 raise", 2'd1);
    read_status(v);
    check("R12 busy read", {27'd0, v}, 32'b00001);
    serve("R12 golden", 2'd1, 1'b1);
    repeat (4) @(negedge clk);
    check("R12 hold", {27'd0, rd_data}, 32'b00001);
    read_status(v);
    check("R12 update", {27'd0, v}, 32'b00011);
  endtask

  initial begin
    t_reset();
    t_golden_only();
    t_upgrade_ok();
    t_upg_absent();
    t_upg_fail();
    t_recovery();
    t_all_fail();
    t_hold();
    t_stray_done();
    t_reset_mid();
    t_read_port();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule